// File: doc/BRIEF.md
# Clear-on-Read Cell Event Counter with Byte Latch

This block counts transmitted valid cells in a 16-bit register that an 8-bit processor bus reads one byte at a time. Each one-cycle pulse from the cell transmitter adds one to the count. The count stops at its maximum value and does not wrap.

A read of either counter byte returns the byte that was asked for. In the same cycle it places the other byte of the same snapshot in a shared read-only latch, and it clears the count. Software reads one byte and then reads the latch, and so rebuilds a 16-bit value that stays consistent while pulses keep arriving. Read data is registered, and an address that is not decoded reads as zero.

Top module: `cellCntRor`

## Requirements
- R1: After reset the count is zero, the latch holds zero and the read-data output is zero.
- R2: Each cycle with the count pulse high and no clearing read adds one to the count.
- R3: Once the count reaches FFFFh it stays there while more pulses arrive.
- R4: A read of address 3Ah returns bits 15:8 of the count and a read of address 3Bh returns bits 7:0. The data appears on the read-data bus in the cycle after the strobe.
- R5: A read of 3Ah or 3Bh copies the byte that was not returned into the latch, taken from the same snapshot as the returned byte.
- R6: A read of 3Ah or 3Bh clears the count. If a pulse arrives in the same cycle as the read, the count becomes 1 instead of 0.
- R7: A read of 3Ch returns the latch and changes neither the latch nor the count.
- R8: A read of any other address returns zero and changes neither the latch nor the count. With no read strobe, the read-data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cellPulse | input | 1 | One-cycle pulse for each transmitted valid cell |
| addr | input | 8 | Byte address of the register being read |
| rdStb | input | 1 | Read strobe, one cycle per read |
| rdData | output | 8 | Registered read data |

## Verification
A wrong count does not show at the ports until the next read of 3Ah or 3Bh, and then it shows one cycle after the strobe. A wrong latch value shows only on the next read of 3Ch. Some faults show up a read later still: a clear that is missed, a pulse lost in the clear cycle, or a latch disturbed by a read of 3Ch or of an undecoded address. For that reason the bench always reads both counter bytes back and keeps a model of the value it expects.

// File: rtl/cellcnt_pkg.sv
package cellcnt_pkg;
  typedef struct packed {
    logic selHi;
    logic selLo;
    logic selHold;
    logic clear;
  } ctlStrobes_t;
endpackage

// File: rtl/cellCntCtl.sv
module cellCntCtl
  import cellcnt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h3A,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h3B,
  parameter logic [ADDR_W-1:0] HOLD_ADDR = 8'h3C
) (
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobes_t       strobes
);
  always_comb begin
    strobes.selHi   = rdStb && (addr == HI_ADDR);
    strobes.selLo   = rdStb && (addr == LO_ADDR);
    strobes.selHold = rdStb && (addr == HOLD_ADDR);
    strobes.clear   = strobes.selHi || strobes.selLo;
  end
endmodule

// File: rtl/cellCntDp.sv
module cellCntDp
  import cellcnt_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  localparam int CNT_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cellPulse,
  input  ctlStrobes_t       strobes,
  output logic [BYTE_W-1:0] rdData
);
  localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  countNext;
  logic [BYTE_W-1:0] holdReg;
  logic [BYTE_W-1:0] hiByte;
  logic [BYTE_W-1:0] loByte;
  logic [BYTE_W-1:0] dataNext;

  assign hiByte = count[CNT_W-1 -: BYTE_W];
  assign loByte = count[BYTE_W-1:0];

  always_comb begin
    if (strobes.clear)
      countNext = {{(CNT_W-1){1'b0}}, cellPulse};
    else if (cellPulse && count != MAX_CNT)
      countNext = count + 1'b1;
    else
      countNext = count;
  end

  always_comb begin
    dataNext = '0;
    if (strobes.selHi)   dataNext = hiByte;
    if (strobes.selLo)   dataNext = loByte;
    if (strobes.selHold) dataNext = holdReg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      holdReg <= '0;
      rdData  <= '0;
    end else begin
      count  <= countNext;
      rdData <= dataNext;
      if (strobes.selHi)
        holdReg <= loByte;
      else if (strobes.selLo)
        holdReg <= hiByte;
    end
  end
endmodule

// File: rtl/cellCntRor.sv
module cellCntRor
  import cellcnt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cellPulse,
  input  logic [7:0] addr,
  input  logic       rdStb,
  output logic [7:0] rdData
);
  ctlStrobes_t strobes;

  cellCntCtl #(.ADDR_W(8)) u_ctl (
    .rdStb(rdStb), .addr(addr), .strobes(strobes)
  );

  cellCntDp #(.BYTE_W(8), .NBYTES(2)) u_dp (
    .clk(clk), .rst(rst), .cellPulse(cellPulse),
    .strobes(strobes), .rdData(rdData)
  );
endmodule

// File: rtl/cellCntRor_chk.sv
module cellCntRor_chk (
  input logic        clk,
  input logic        rst,
  input logic        cellPulse,
  input logic [7:0]  addr,
  input logic        rdStb,
  input logic [7:0]  rdData,
  input logic [15:0] count,
  input logic [7:0]  holdReg
);
  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (count == 16'h0 && holdReg == 8'h0 && rdData == 8'h0)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cellPulse && !(rdStb && (addr == 8'h3A || addr == 8'h3B)) && count != 16'hFFFF) |=> count == $past(count) + 16'h1); // R2
  AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (count == 16'hFFFF && !(rdStb && (addr == 8'h3A || addr == 8'h3B))) |=> count == 16'hFFFF); // R3
  AST_HI_READ: assert property (@(posedge clk) disable iff (rst)
    (rdStb && addr == 8'h3A) |=> (rdData == $past(count[15:8]) && holdReg == $past(count[7:0]))); // R4
  AST_LO_LATCH: assert property (@(posedge clk) disable iff (rst)
    (rdStb && addr == 8'h3B) |=> (rdData == $past(count[7:0]) && holdReg == $past(count[15:8]))); // R5
  AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rdStb && (addr == 8'h3A || addr == 8'h3B)) |=> count == {15'h0, $past(cellPulse)}); // R6
  AST_HOLD_READ: assert property (@(posedge clk) disable iff (rst)
    (rdStb && addr == 8'h3C) |=> (rdData == $past(holdReg) && $stable(holdReg))); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(rdStb && (addr == 8'h3A || addr == 8'h3B || addr == 8'h3C)) |=> (rdData == 8'h0 && $stable(holdReg))); // R8
endmodule

bind cellCntRor cellCntRor_chk u_chk (
  .clk(clk), .rst(rst), .cellPulse(cellPulse), .addr(addr), .rdStb(rdStb),
  .rdData(rdData), .count(u_dp.count), .holdReg(u_dp.holdReg)
);

// File: tb/test_cellCntRor.sv
module test_cellCntRor;
  logic clk = 1'b0;
  logic rst;
  logic cellPulse;
  logic [7:0] addr;
  logic rdStb;
  logic [7:0] rdData;

  int nChecks = 0;
  int nFails = 0;
  int mCount = 0;
  logic [7:0] mHold = 8'h0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cellCntRor i_cellCntRor (
    .clk(clk), .rst(rst), .cellPulse(cellPulse),
    .addr(addr), .rdStb(rdStb), .rdData(rdData)
  );

  function automatic int satInc(int c);
    return (c >= 65535) ? 65535 : c + 1;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(logic p, logic rd, logic [7:0] a, string req, bit doChk);
    logic [7:0] expData;
    cellPulse = p; rdStb = rd; addr = a;
    expData = 8'h0;
    if (rd && a == 8'h3A) begin expData = mCount[15:8]; mHold = mCount[7:0]; end
    else if (rd && a == 8'h3B) begin expData = mCount[7:0]; mHold = mCount[15:8]; end
    else if (rd && a == 8'h3C) expData = mHold;
    if (rd && (a == 8'h3A || a == 8'h3B)) mCount = p ? 1 : 0;
    else if (p) mCount = satInc(mCount);
    @(posedge clk); #2;
    cellPulse = 1'b0; rdStb = 1'b0;
    if (doChk) check(req, rdData, expData);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00, "R2", 1'b0);
  endtask

  initial begin
    #1500000;
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rst = 1'b1; cellPulse = 1'b0; rdStb = 1'b0; addr = 8'h00;
    repeat (3) @(posedge clk);
    #2 check("R1", rdData, 8'h00);
    rst = 1'b0;
    step(1'b0, 1'b1, 8'h3B, "R1", 1'b1);
    step(1'b0, 1'b1, 8'h3C, "R1", 1'b1);
    pulses(5);
    step(1'b0, 1'b1, 8'h3B, "R2", 1'b1);
    step(1'b0, 1'b1, 8'h3B, "R6", 1'b1);
    pulses(300);
    step(1'b0, 1'b1, 8'h3A, "R4", 1'b1);
    step(1'b0, 1'b1, 8'h3C, "R5", 1'b1);
    step(1'b0, 1'b1, 8'h3C, "R7", 1'b1);
    pulses(260);
    step(1'b1, 1'b1, 8'h3B, "R6", 1'b1);
    step(1'b0, 1'b1, 8'h3B, "R6", 1'b1);
    step(1'b0, 1'b1, 8'h3C, "R5", 1'b1);
    pulses(2);
    step(1'b0, 1'b1, 8'h3C, "R7", 1'b1);
    step(1'b0, 1'b1, 8'h55, "R8", 1'b1);
    step(1'b0, 1'b0, 8'h3A, "R8", 1'b1);
    step(1'b0, 1'b1, 8'h3C, "R8", 1'b1);
    step(1'b0, 1'b1, 8'h3A, "R7", 1'b1);
    pulses(65540);
    step(1'b0, 1'b1, 8'h3A, "R3", 1'b1);
    step(1'b0, 1'b1, 8'h3C, "R3", 1'b1);
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] k;
      logic [7:0] a;
      k = 3'($urandom_range(0, 5));
      a = (k == 0) ? 8'h3A : (k == 1) ? 8'h3B : (k == 2) ? 8'h3C : (k == 3) ? 8'h3D : 8'h00;
      step(1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0), a, "R5", 1'b1);
    end
    step(1'b0, 1'b1, 8'h3A, "R4", 1'b1);
    step(1'b0, 1'b1, 8'h3B, "R4", 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule